// File: doc/BRIEF.md
# Idle-Timeout Power State Controller

This block sequences a subsystem through four power states using a one-millisecond tick enable. It counts the ticks since the most recent activity pulse. When that count reaches the idle timeout, or when a sleep request has been latched, it leaves the active state. It then enters a sleep-pending phase, which lasts for a fixed number of ticks while an external indicator fades. After that it enters a sleeping state and asserts a peripheral gate output.

An activity pulse brings the block back to active through a one-tick waking state. A hardware wake event seen while sleeping returns the block to active directly. Either path releases the gate. The outputs are the state code, the gate, the idle millisecond count and a one-cycle strobe that marks the start of the fade phase.

The tick, activity, request and wake inputs are single-cycle pulses that are synchronous to the clock. The asynchronous active-low reset is synchronized inside the block before it is released.

Top module: `pwr_idle_seq`

## Requirements
- R1: After reset the block is in the active state, with the gate low, the idle count at zero, the strobe low and no request latched.
- R2: The state output uses the codes active=0, sleep-pending=1, sleeping=2 and waking=3. Without a tick, an activity pulse or a wake pulse, the state does not change.
- R3: Each tick adds one to the idle count, and an activity pulse clears it to zero. In the active state, the tick that raises the count to IDLE_TIMEOUT moves the block to sleep-pending and raises the fade-start strobe for one cycle. Before that tick the count reads IDLE_TIMEOUT-1.
- R4: A sleep-request pulse is latched. In the active state, the next tick moves the block to sleep-pending whatever the idle count is. Entering sleep-pending clears the latch.
- R5: In sleep-pending the gate stays low. The FADE_TIME-th tick after the entry tick moves the block to sleeping and raises the gate at the same moment. The gate is high only in sleeping or waking.
- R6: An activity pulse in sleep-pending or sleeping moves the block to waking on the next cycle and clears any latched request. Waking becomes active on the next tick, and the gate drops at that moment.
- R7: A wake pulse in sleeping moves the block to active on the next cycle, drops the gate and clears the idle count. A wake pulse in any other state has no effect.
- R8: The idle count saturates at its all-ones value and never wraps.
- R9: An activity pulse takes precedence. If a request arrives in the same cycle as an activity pulse, the request is not latched. If a tick arrives in the same cycle as an activity pulse, the idle count is cleared and no transition happens.
- R10: A request that arrives while the block is sleep-pending or sleeping stays latched across a wake pulse. The first tick back in the active state then re-enters sleep-pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_ms | input | 1 | One-cycle pulse for each elapsed millisecond |
| activity_i | input | 1 | Activity pulse |
| sleep_req_i | input | 1 | Explicit sleep request pulse |
| wake_i | input | 1 | Hardware wake pulse, acted on only while sleeping |
| state_o | output | 2 | Current power state code |
| gate_o | output | 1 | Peripheral gate; high means the peripherals are gated |
| idle_ms_o | output | IDLE_W | Ticks since the last activity, saturating |
| fade_start_o | output | 1 | One-cycle strobe on entry to sleep-pending |

## Verification
The hardest situation to reach is a request latched during sleep-pending that survives a wake pulse. It also has to be told apart from a re-entry caused by the idle timeout. To reach it, the bench sets a request during the fade, lets the block fall asleep, and wakes it with wake_i, which clears the idle count. It then applies one tick, so the only reason left for re-entering sleep-pending is the surviving request. The bench also sweeps the point at which a request or an activity pulse lands, covering every idle count below the timeout and every fade phase. It uses a small configuration so that saturation is reached within a few dozen ticks.

// File: rtl/pwr_idle_pkg.sv
package pwr_idle_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_PENDING = 2'd1,
    PS_ASLEEP  = 2'd2,
    PS_WAKING  = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pwr_sat_ctr.sv
module pwr_sat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CMAX = '1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                       cnt_d = '0;
    else if (inc && cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CTR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && !clr) |=> (cnt_q == CMAX)); // R8
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_idle_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       activity_i,
  input  logic       sleep_req_i,
  input  logic       wake_i,
  input  logic       idle_hit_i,
  input  logic       fade_done_i,
  output pwr_state_e state_o,
  output logic       gate_o,
  output logic       fade_start_o,
  output logic       idle_clr_o,
  output logic       fade_clr_o,
  output logic       fade_inc_o
);
  pwr_state_e st_q, st_d;
  logic req_q, req_d, gate_q, gate_d, fs_q, fs_d;

  always_comb begin
    st_d       = st_q;
    req_d      = req_q | sleep_req_i;
    gate_d     = gate_q;
    fs_d       = 1'b0;
    idle_clr_o = 1'b0;
    fade_clr_o = 1'b0;
    if (activity_i) begin
      idle_clr_o = 1'b1;
      req_d      = req_q;
      if (st_q != PS_ACTIVE) begin
        st_d  = PS_WAKING;
        req_d = 1'b0;
      end
    end else if (st_q == PS_ASLEEP && wake_i) begin
      st_d       = PS_ACTIVE;
      gate_d     = 1'b0;
      idle_clr_o = 1'b1;
    end else if (tick_i) begin
      unique case (st_q)
        PS_ACTIVE: if (req_q || idle_hit_i) begin
          st_d       = PS_PENDING;
          req_d      = 1'b0;
          fade_clr_o = 1'b1;
          fs_d       = 1'b1;
        end
        PS_PENDING: if (fade_done_i) begin
          st_d   = PS_ASLEEP;
          gate_d = 1'b1;
        end
        PS_WAKING: begin
          st_d   = PS_ACTIVE;
          gate_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign fade_inc_o = tick_i && !activity_i && (st_q == PS_PENDING);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_ACTIVE;
      req_q  <= 1'b0;
      gate_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      req_q  <= req_d;
      gate_q <= gate_d;
      fs_q   <= fs_d;
    end
  end

  assign state_o      = st_q;
  assign gate_o       = gate_q;
  assign fade_start_o = fs_q;

  AST_GATE_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> (st_q == PS_ASLEEP || st_q == PS_WAKING)); // R5
  AST_STROBE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> (st_q == PS_PENDING)); // R3
  AST_WAKING_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_WAKING && tick_i && !activity_i) |=> (st_q == PS_ACTIVE && !gate_q)); // R6
  AST_WAKE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_ASLEEP && wake_i && !activity_i) |=> (st_q == PS_ACTIVE && !gate_q)); // R7
  AST_ACT_TO_WAKING: assert property (@(posedge clk) disable iff (!rst_n)
    (activity_i && st_q != PS_ACTIVE) |=> (st_q == PS_WAKING)); // R6
endmodule

// File: rtl/pwr_idle_seq.sv
module pwr_idle_seq
  import pwr_idle_pkg::*;
#(
  parameter int IDLE_TIMEOUT = 30000,
  parameter int FADE_TIME    = 3000,
  parameter int IDLE_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              activity_i,
  input  logic              sleep_req_i,
  input  logic              wake_i,
  output logic [1:0]        state_o,
  output logic              gate_o,
  output logic [IDLE_W-1:0] idle_ms_o,
  output logic              fade_start_o
);
  localparam int FADE_W = $clog2(FADE_TIME + 1);
  localparam logic [IDLE_W-1:0] IDLE_HIT_AT  = IDLE_W'(IDLE_TIMEOUT - 1);
  localparam logic [FADE_W-1:0] FADE_DONE_AT = FADE_W'(FADE_TIME - 1);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic              idle_clr, fade_clr, fade_inc;
  logic [IDLE_W-1:0] idle_cnt;
  logic [FADE_W-1:0] fade_cnt;
  pwr_state_e        st;

  pwr_sat_ctr #(.W(IDLE_W)) u_idle_ctr (
    .clk(clk), .rst_n(rst_sync_n), .clr(idle_clr),
    .inc(tick_ms && !idle_clr), .cnt(idle_cnt)
  );

  pwr_sat_ctr #(.W(FADE_W)) u_fade_ctr (
    .clk(clk), .rst_n(rst_sync_n), .clr(fade_clr),
    .inc(fade_inc), .cnt(fade_cnt)
  );

  pwr_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .tick_i(tick_ms),
    .activity_i(activity_i), .sleep_req_i(sleep_req_i), .wake_i(wake_i),
    .idle_hit_i(idle_cnt >= IDLE_HIT_AT), .fade_done_i(fade_cnt >= FADE_DONE_AT),
    .state_o(st), .gate_o(gate_o), .fade_start_o(fade_start_o),
    .idle_clr_o(idle_clr), .fade_clr_o(fade_clr), .fade_inc_o(fade_inc)
  );

  assign state_o   = st;
  assign idle_ms_o = idle_cnt;

  AST_ACT_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    activity_i |=> (idle_ms_o == '0)); // R3
  AST_PENDING_UNGATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_o == 2'd1) |-> !gate_o); // R5
endmodule

// File: tb/pwr_idle_seq_tb.sv
module pwr_idle_seq_tb;
  localparam int TO = 10;
  localparam int FD = 4;
  localparam int W  = 5;
  localparam int SAT = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, activity_i = 1'b0, sleep_req_i = 1'b0, wake_i = 1'b0;
  logic [1:0]   state_o;
  logic         gate_o, fade_start_o;
  logic [W-1:0] idle_ms_o;
  int checks = 0, errors = 0;
  int exp_idle;

  always #10 clk = ~clk;

  pwr_idle_seq #(.IDLE_TIMEOUT(TO), .FADE_TIME(FD), .IDLE_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .activity_i(activity_i),
    .sleep_req_i(sleep_req_i), .wake_i(wake_i), .state_o(state_o),
    .gate_o(gate_o), .idle_ms_o(idle_ms_o), .fade_start_o(fade_start_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic tk, input logic act, input logic rq, input logic wk);
    tick_ms = tk; activity_i = act; sleep_req_i = rq; wake_i = wk;
    @(negedge clk);
    tick_ms = 0; activity_i = 0; sleep_req_i = 0; wake_i = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 state", state_o, 0); chk("R1 gate", gate_o, 0);
    chk("R1 idle", idle_ms_o, 0); chk("R1 strobe", fade_start_o, 0);
    // R1: no request latched -> a tick stays active
    cyc(1,0,0,0); chk("R1 no req", state_o, 0);
    do_reset();
    // R3 idle count up to the timeout
    for (int i = 1; i < TO; i++) begin
      cyc(1,0,0,0); chk("R3 idle", idle_ms_o, i); chk("R3 active", state_o, 0);
      cyc(0,0,0,0); chk("R2 hold", idle_ms_o, i);
    end
    chk("R3 one before", idle_ms_o, TO-1);
    cyc(1,0,0,0); chk("R3 pending", state_o, 1); chk("R3 strobe", fade_start_o, 1);
    cyc(0,0,0,0); chk("R3 strobe one cycle", fade_start_o, 0); chk("R2 no tick", state_o, 1);
    // R5 fade
    exp_idle = TO;
    for (int f = 1; f <= FD; f++) begin
      cyc(1,0,0,0); exp_idle++;
      chk("R5 state", state_o, (f == FD) ? 2 : 1);
      chk("R5 gate", gate_o, (f == FD) ? 1 : 0);
    end
    // R8 saturation while sleeping
    for (int s = 0; s < 25; s++) begin
      cyc(1,0,0,0); exp_idle++;
      chk("R8 idle sat", idle_ms_o, (exp_idle > SAT) ? SAT : exp_idle);
    end
    chk("R2 asleep stays", state_o, 2);
    // R7 wake in sleeping
    cyc(0,0,0,1); chk("R7 active", state_o, 0); chk("R7 gate", gate_o, 0); chk("R7 idle", idle_ms_o, 0);
    cyc(1,0,0,0); cyc(0,0,0,1);
    chk("R7 wake ignored idle", idle_ms_o, 1); chk("R7 wake ignored state", state_o, 0);
    // R6 activity while sleeping
    cyc(0,0,1,0); cyc(1,0,0,0); chk("R4 req pending", state_o, 1);
    repeat (FD) cyc(1,0,0,0);
    chk("R5 asleep", state_o, 2);
    cyc(0,1,0,0); chk("R6 waking", state_o, 3); chk("R6 gate held", gate_o, 1); chk("R6 idle", idle_ms_o, 0);
    cyc(0,0,0,0); chk("R2 waking hold", state_o, 3);
    cyc(1,0,0,0); chk("R6 resolved", state_o, 0); chk("R6 gate low", gate_o, 0);
    // R6 activity at each fade phase
    for (int p = 0; p < FD; p++) begin
      do_reset();
      cyc(0,0,1,0); cyc(1,0,0,0);
      repeat (p) cyc(1,0,0,0);
      chk("R6 sweep pending", state_o, 1);
      cyc(0,1,0,0); chk("R6 sweep waking", state_o, 3);
      cyc(1,0,0,0); chk("R6 sweep active", state_o, 0); chk("R6 sweep idle", idle_ms_o, 1);
    end
    // R4 request at each idle count
    for (int k = 0; k < TO-1; k++) begin
      do_reset();
      repeat (k) cyc(1,0,0,0);
      cyc(0,0,1,0); chk("R4 latched no tick", state_o, 0);
      cyc(1,0,0,0); chk("R4 pending", state_o, 1); chk("R4 strobe", fade_start_o, 1);
    end
    // R9 activity wins over request
    do_reset();
    cyc(0,1,1,0); cyc(1,0,0,0); chk("R9 req dropped", state_o, 0); chk("R9 idle", idle_ms_o, 1);
    repeat (TO-2) cyc(1,0,0,0);
    chk("R9 pre", idle_ms_o, TO-1);
    cyc(1,1,0,0); chk("R9 tick+act state", state_o, 0); chk("R9 tick+act idle", idle_ms_o, 0);
    // R10 request survives wake
    do_reset();
    cyc(0,0,1,0); cyc(1,0,0,0);
    cyc(0,0,1,0);
    repeat (FD) cyc(1,0,0,0);
    chk("R10 asleep", state_o, 2);
    cyc(0,0,0,1); chk("R10 woke", state_o, 0);
    cyc(1,0,0,0); chk("R10 re-pend", state_o, 1); chk("R10 idle low", idle_ms_o, 1);
    // R6 activity clears latched request
    cyc(0,0,1,0); cyc(0,1,0,0); chk("R6 waking2", state_o, 3);
    cyc(1,0,0,0); cyc(1,0,0,0); chk("R6 req cleared", state_o, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule